// File: doc/BRIEF.md
# Split-Read Clock Timer With Hold

This block is a free-running 8-bit binary timer advanced by a 256 Hz enable pulse. Each bit is a divided-down square wave: bit 0 runs at 128 Hz and bit 7 at 1 Hz. A processor with a 4-bit data path reads the timer as two nibbles at two addresses. The lower nibble covers the 128 Hz to 16 Hz bits and the upper nibble covers the 8 Hz to 1 Hz bits.

Two separate reads can straddle a carry and return an incoherent pair. To prevent this, a read of the lower nibble freezes the upper nibble. If a carry leaves the lower nibble while the upper nibble is frozen, the carry is stored as one pending increment. The freeze ends when the upper nibble is read or when a short timeout expires, whichever comes first, and the pending increment is applied on that same clock edge. The timeout counts pulses of a second, faster enable.

The block also produces one-cycle interrupt request pulses when the 32 Hz, 8 Hz, 2 Hz or 1 Hz bit falls. A synchronous clear input restarts the timer.

Top module: `clktmr_split_read`

## Requirements
- R1: After the asynchronous reset, both nibbles read 0 and all interrupt requests are 0.
- R2: Each cycle with `tick_256` high and `tmr_clr` low adds one to the 8-bit count, modulo 256. Without a freeze, the upper nibble (bits 7..4) increments on the same edge at which the lower nibble (bits 3..0) wraps from 15 to 0.
- R3: `rd_data` is combinational and reflects the count before the edge that ends the read cycle. It returns bits 3..0 when `rd_en` is high and `rd_addr` equals `LO_ADDR` (default E3h). It returns bits 7..4 when `rd_addr` equals `HI_ADDR` (default E4h). In every other case it is 0.
- R4: A lower-nibble read starts a freeze. A carry out of the lower nibble at the edge ending that read, or at any later edge while the freeze lasts, leaves the upper nibble unchanged.
- R5: An upper-nibble read during a freeze returns the frozen value and ends the freeze. A pending increment is applied at the edge that ends that read.
- R6: If no upper-nibble read arrives, the freeze ends on the `HOLD_TICKS`-th (default 2nd) `tick_fast` pulse after the lower-nibble read cycle, and any pending increment is applied at that edge. One pulse does not end it.
- R7: An upper-nibble read never starts a freeze. A carry that follows such a read reaches the upper nibble at once.
- R8: A lower-nibble read during an active freeze does not restart the timeout.
- R9: `irq_req[0]`, `irq_req[1]`, `irq_req[2]` and `irq_req[3]` pulse high for exactly one cycle, in the cycle after count bit 2, 4, 6 or 7 (respectively) changes from 1 to 0.
- R10: `tmr_clr` has priority over a same-cycle tick. At the next edge it zeroes the count, the pending increment and the freeze, and the clear itself raises no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_256 | input | 1 | One-cycle 256 Hz count enable |
| tick_fast | input | 1 | One-cycle enable that times the freeze |
| tmr_clr | input | 1 | Synchronous timer clear |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | NIB_W | Read data nibble |
| irq_req | output | 4 | Interrupt request pulses (32 Hz, 8 Hz, 2 Hz, 1 Hz falls) |

## Verification
A lost or stuck pending increment appears one upper-nibble read later as an upper value off by one, so the bench reads both nibbles right after every freeze ends. A timeout counter that is off by one shows up as a premature or missing increment at the first upper read after a single fast pulse. A stale edge-detect register shows up as a spurious or doubled interrupt pulse in the cycle after a clear or a fall. Counting pulses over a full 256-tick wrap exposes any miscount within one timer period.

// File: rtl/clktmr_pkg.sv
`timescale 1ns/1ps
package clktmr_pkg;

   localparam int unsigned IRQ_N = 4;

   typedef enum logic [0:0] {
      FRZ_IDLE   = 1'b0,
      FRZ_ACTIVE = 1'b1
   } frz_state_e;

   // count bit whose falling edge drives interrupt request k
   function automatic int unsigned irq_src_bit(input int unsigned k);
      case (k)
         0:       return 2;
         1:       return 4;
         2:       return 6;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/clktmr_freeze_ctl.sv
`timescale 1ns/1ps
module clktmr_freeze_ctl #(
   parameter int unsigned HOLD_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lo_rd,
   input  logic hi_rd,
   input  logic tick_fast,
   output logic frz_eff,
   output logic frz_release,
   output logic frz_active
);
   import clktmr_pkg::*;

   localparam int unsigned TW = $clog2(HOLD_TICKS + 1);
   localparam logic [TW-1:0] LAST_CNT = TW'(HOLD_TICKS - 1);

   frz_state_e   state_q;
   logic [TW-1:0] tcnt_q;

   assign frz_active  = (state_q == FRZ_ACTIVE);
   assign frz_release = frz_active & (hi_rd | (tick_fast & (tcnt_q == LAST_CNT)));
   // freeze applies at this edge when starting now or still held
   assign frz_eff     = frz_active ? ~frz_release : lo_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FRZ_IDLE;
         tcnt_q  <= '0;
      end else if (clr) begin
         state_q <= FRZ_IDLE;
         tcnt_q  <= '0;
      end else begin
         case (state_q)
            FRZ_IDLE: begin
               if (lo_rd) begin
                  state_q <= FRZ_ACTIVE;
                  tcnt_q  <= '0;
               end
            end
            default: begin
               if (frz_release) begin
                  state_q <= FRZ_IDLE;
                  tcnt_q  <= '0;
               end else if (tick_fast) begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/clktmr_counter.sv
`timescale 1ns/1ps
module clktmr_counter #(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned CNT_W = 2 * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             frz_eff,
   output logic [CNT_W-1:0] cnt,
   output logic             pend
);
   logic [NIB_W-1:0] lo_q, hi_q;
   logic             pend_q;
   logic             carry;
   logic [1:0]       hi_inc;

   assign carry  = tick & (&lo_q);
   assign hi_inc = frz_eff ? 2'd0 : ({1'b0, carry} + {1'b0, pend_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         pend_q <= 1'b0;
      end else if (clr) begin
         lo_q   <= '0;
         hi_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         if (tick) lo_q <= lo_q + 1'b1;
         hi_q <= hi_q + NIB_W'(hi_inc);
         if (frz_eff) begin
            if (carry) pend_q <= 1'b1;
         end else begin
            pend_q <= 1'b0;
         end
      end
   end

   assign cnt  = {hi_q, lo_q};
   assign pend = pend_q;

endmodule

// File: rtl/clktmr_irq_gen.sv
`timescale 1ns/1ps
module clktmr_irq_gen #(
   parameter int unsigned CNT_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic [CNT_W-1:0]           cnt,
   output logic [clktmr_pkg::IRQ_N-1:0] irq
);
   import clktmr_pkg::*;

   for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
      localparam int unsigned SB = irq_src_bit(k);
      if (SB >= CNT_W) begin : g_bad
         $error("interrupt source bit outside the counter");
      end
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   prev_q <= 1'b0;
         else if (clr) prev_q <= 1'b0;
         else          prev_q <= cnt[SB];
      end
      assign irq[k] = prev_q & ~cnt[SB];
   end

endmodule

// File: rtl/clktmr_split_read.sv
`timescale 1ns/1ps
module clktmr_split_read #(
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [7:0]  LO_ADDR    = 8'hE3,
   parameter logic [7:0]  HI_ADDR    = 8'hE4,
   parameter int unsigned HOLD_TICKS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick_256,
   input  logic                         tick_fast,
   input  logic                         tmr_clr,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [NIB_W-1:0]             rd_data,
   output logic [clktmr_pkg::IRQ_N-1:0] irq_req
);
   localparam int unsigned CNT_W = 2 * NIB_W;
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

   if (NIB_W < 2) begin : g_chk_nib
      $error("NIB_W must be at least 2");
   end
   if (LO_A == HI_A) begin : g_chk_addr
      $error("nibble addresses must differ");
   end
   if (HOLD_TICKS < 1) begin : g_chk_hold
      $error("HOLD_TICKS must be at least 1");
   end

   logic             lo_rd, hi_rd;
   logic             frz_eff, frz_release, frz_active;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   assign lo_rd = rd_en & (rd_addr == LO_A);
   assign hi_rd = rd_en & (rd_addr == HI_A);

   clktmr_freeze_ctl #(.HOLD_TICKS(HOLD_TICKS)) u_frz (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (tmr_clr),
      .lo_rd       (lo_rd),
      .hi_rd       (hi_rd),
      .tick_fast   (tick_fast),
      .frz_eff     (frz_eff),
      .frz_release (frz_release),
      .frz_active  (frz_active)
   );

   clktmr_counter #(.NIB_W(NIB_W), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .tick    (tick_256),
      .frz_eff (frz_eff),
      .cnt     (cnt_q),
      .pend    (pend_q)
   );

   clktmr_irq_gen #(.CNT_W(CNT_W)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cnt   (cnt_q),
      .irq   (irq_req)
   );

   always_comb begin
      rd_data = '0;
      if (lo_rd)      rd_data = cnt_q[NIB_W-1:0];
      else if (hi_rd) rd_data = cnt_q[CNT_W-1:NIB_W];
   end

endmodule

// File: rtl/clktmr_split_read_chk.sv
`timescale 1ns/1ps
module clktmr_split_read_chk #(
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned ADDR_W = 8,
   parameter logic [7:0]  LO_ADDR = 8'hE3,
   parameter logic [7:0]  HI_ADDR = 8'hE4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         tick_256,
   input logic                         tmr_clr,
   input logic                         rd_en,
   input logic [ADDR_W-1:0]            rd_addr,
   input logic [NIB_W-1:0]             rd_data,
   input logic [clktmr_pkg::IRQ_N-1:0] irq_req,
   input logic [2*NIB_W-1:0]           cnt,
   input logic                         pend,
   input logic                         frz_active,
   input logic                         frz_release
);
   localparam int unsigned CNT_W = 2 * NIB_W;
   logic lo_hit, hi_hit;
   assign lo_hit = rd_en && (rd_addr == ADDR_W'(LO_ADDR));
   assign hi_hit = rd_en && (rd_addr == ADDR_W'(HI_ADDR));

   a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr |=> (cnt == '0) && !pend && !frz_active);

   a_r2_low_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_256 && !tmr_clr) |=> cnt[NIB_W-1:0] == NIB_W'($past(cnt[NIB_W-1:0]) + 1'b1));

   a_r2_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_256 && !tmr_clr && !pend) |=> $stable(cnt));

   a_r4_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_active && !frz_release && !tmr_clr) |=> $stable(cnt[CNT_W-1:NIB_W]));

   a_r4_hi_frozen_start: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_hit && !frz_active && !tmr_clr) |=> $stable(cnt[CNT_W-1:NIB_W]));

   a_r5_pend_drained: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_active && hi_hit && !tmr_clr) |=> !pend && !frz_active);

   a_r7_hi_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_hit && !frz_active) |=> !frz_active);

   a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));

   a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |=> ((irq_req & $past(irq_req)) == '0));

endmodule

bind clktmr_split_read clktmr_split_read_chk #(
   .NIB_W(NIB_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_256    (tick_256),
   .tmr_clr     (tmr_clr),
   .rd_en       (rd_en),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .irq_req     (irq_req),
   .cnt         (cnt_q),
   .pend        (pend_q),
   .frz_active  (frz_active),
   .frz_release (frz_release)
);

// File: tb/clktmr_split_read_tb.sv
`timescale 1ns/1ps
module clktmr_split_read_tb_top;
   localparam int CLK_P = 10;
   localparam logic [7:0] A_LO = 8'hE3;
   localparam logic [7:0] A_HI = 8'hE4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_256 = 1'b0, tick_fast = 1'b0, tmr_clr = 1'b0, rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [3:0] rd_data;
   logic [3:0] irq_req;

   int n_chk = 0, n_fail = 0;
   int irq_cnt [4];
   logic [3:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_P/2) clk = ~clk;

   clktmr_split_read dut_i (
      .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .tick_fast(tick_fast),
      .tmr_clr(tmr_clr), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_req(irq_req)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // scoreboard monitor: pops the expected nibble for every read cycle
   always @(negedge clk) begin
      #(CLK_P/4);
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard empty", rd_data, 0);
         end else begin
            automatic logic [3:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_data == e, t, rd_data, e);
         end
      end
      for (int k = 0; k < 4; k++) if (irq_req[k]) irq_cnt[k]++;
   end

   task automatic do_read(input logic [7:0] a, input logic [3:0] e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0; rd_addr = '0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_256 = 1'b1;
         @(negedge clk); tick_256 = 1'b0;
      end
   endtask

   task automatic tickf();
      @(negedge clk); tick_fast = 1'b1;
      @(negedge clk); tick_fast = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 200000);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int snap;
      for (int k = 0; k < 4; k++) irq_cnt[k] = 0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      #(CLK_P/4);
      check(irq_req == 4'h0, "R1 irq after reset", irq_req, 0);
      check(rd_data == 4'h0, "R3 idle bus zero", rd_data, 0);
      do_read(A_LO, 4'h0, "R1 low after reset");
      do_read(A_HI, 4'h0, "R1 high after reset");

      tick(5);
      do_read(A_LO, 4'h5, "R2 low after five ticks");
      do_read(A_HI, 4'h0, "R2 high after five ticks");
      do_read(8'hE5, 4'h0, "R3 unmatched address");

      // R4 / R5: carry during freeze is deferred until high read
      tick(10);
      do_read(A_LO, 4'hF, "R4 low before carry");
      tick(1);
      do_read(A_LO, 4'h0, "R4 low after wrap in freeze");
      do_read(A_HI, 4'h0, "R4 high frozen");
      do_read(A_LO, 4'h0, "R5 low after release");
      do_read(A_HI, 4'h1, "R5 pending applied");

      // R7: high read never freezes
      tick(15);
      do_read(A_HI, 4'h1, "R7 high before carry");
      tick(1);
      do_read(A_HI, 4'h2, "R7 carry reaches high at once");
      do_read(A_LO, 4'h0, "R7 low");
      do_read(A_HI, 4'h2, "R7 high");

      // R6: one fast pulse does not end the freeze
      tick(15);
      do_read(A_LO, 4'hF, "R6 low before carry");
      tick(1);
      tickf();
      do_read(A_HI, 4'h2, "R6 still frozen after one pulse");
      do_read(A_LO, 4'h0, "R6 low");
      do_read(A_HI, 4'h3, "R6 pending applied by high read");

      // R6: second pulse ends the freeze
      tick(15);
      do_read(A_LO, 4'hF, "R6 low before carry b");
      tick(1);
      tickf();
      tickf();
      do_read(A_HI, 4'h4, "R6 released by timeout");

      // R8: re-read of low does not restart the timeout
      tick(15);
      do_read(A_LO, 4'hF, "R8 first low read");
      tickf();
      do_read(A_LO, 4'hF, "R8 second low read");
      tick(1);
      tickf();
      do_read(A_HI, 4'h5, "R8 timeout not restarted");

      // R10: clear with pending carry and same-cycle tick
      tick(15);
      do_read(A_LO, 4'hF, "R10 low before carry");
      tick(1);
      idle(3);
      snap = irq_cnt[0] + irq_cnt[1] + irq_cnt[2] + irq_cnt[3];
      @(negedge clk); tmr_clr = 1'b1; tick_256 = 1'b1;
      @(negedge clk); tmr_clr = 1'b0; tick_256 = 1'b0;
      idle(3);
      check((irq_cnt[0] + irq_cnt[1] + irq_cnt[2] + irq_cnt[3]) == snap,
            "R10 clear raises no irq", irq_cnt[0] + irq_cnt[1] + irq_cnt[2] + irq_cnt[3], snap);
      do_read(A_LO, 4'h0, "R10 low cleared");
      do_read(A_HI, 4'h0, "R10 high cleared");
      tick(16);
      do_read(A_LO, 4'h0, "R10 low after wrap");
      do_read(A_HI, 4'h1, "R10 stale pending dropped");

      // R9: interrupt pulses over one full wrap
      @(negedge clk); tmr_clr = 1'b1;
      @(negedge clk); tmr_clr = 1'b0;
      idle(2);
      for (int k = 0; k < 4; k++) irq_cnt[k] = 0;
      tick(8);
      #(CLK_P/4);
      check(irq_req == 4'b0001, "R9 32Hz pulse after bit 2 falls", irq_req, 1);
      @(negedge clk); #(CLK_P/4);
      check(irq_req == 4'b0000, "R9 pulse lasts one cycle", irq_req, 0);
      tick(248);
      idle(2);
      check(irq_cnt[0] == 32, "R9 irq0 count", irq_cnt[0], 32);
      check(irq_cnt[1] == 8,  "R9 irq1 count", irq_cnt[1], 8);
      check(irq_cnt[2] == 2,  "R9 irq2 count", irq_cnt[2], 2);
      check(irq_cnt[3] == 1,  "R9 irq3 count", irq_cnt[3], 1);
      do_read(A_LO, 4'h0, "R2 low after full wrap");
      do_read(A_HI, 4'h0, "R2 high after full wrap");

      idle(3);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule